// File: doc/BRIEF.md
# Masked interrupt status controller

This block gathers interrupt requests from peripherals into a 16-bit status register. Each request bit is sticky until software acknowledges it. A 16-bit enable mask selects which status bits may reach the processor. The block drives one combined, registered interrupt line that is high whenever an enabled status bit is set.

Software reaches both registers through a small single-cycle register bus. Writing the status register acknowledges requests by AND. A zero bit in the written word clears that request, and a one bit keeps it. Writing the mask replaces it. When the new mask leaves an enabled request pending, the block also emits a one-cycle re-check strobe, so the processor side can re-examine its interrupt state.

One status bit is reserved for the DMA controller's request, which has its own input. Reads return the selected register zero-extended to the bus width, one cycle after the request.

Top module: `irq_mask_ctl`

## Requirements
- R1: A synchronous, active-high reset clears the status register, the mask register, `cpu_irq`, `recheck`, `bus_rvalid` and `bus_rdata` to zero.
- R2: A one on any bit of `irq_set` in a cycle sets the matching status bit at the next clock edge. The bit then stays set until software clears it.
- R3: A write to offset 0x070 (status) stores the old status AND `bus_wdata[15:0]`. A written 0 clears a bit and a written 1 leaves it unchanged.
- R4: When a set request and an acknowledge write hit the same status bit in the same cycle, the bit ends up set.
- R5: A write to offset 0x074 (mask) replaces the mask with `bus_wdata[15:0]`. Bits 31:16 of a write are ignored for both registers.
- R6: `cpu_irq` equals the OR of (status AND mask) as those registers stood one clock earlier. It therefore follows any register change by exactly one cycle.
- R7: After a mask write, `recheck` is high for exactly the cycle in which `cpu_irq` first reflects the new mask. It is high only if (status AND new mask) is nonzero, and never rises without a mask write two edges earlier.
- R8: A read (`bus_valid` high, `bus_write` low) returns the addressed register zero-extended on `bus_rdata`, with `bus_rvalid` high, one cycle later. A read of any other offset returns zero. A write to any other offset changes neither register.
- R9: A pulse on `dma_irq` sets status bit 3, exactly as `irq_set[3]` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data; only bits 15:0 are used |
| bus_rdata | output | 32 | Registered read data, zero-extended |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| irq_set | input | 16 | Per-bit request pulses from peripherals |
| dma_irq | input | 1 | DMA controller request; sets status bit 3 |
| cpu_irq | output | 1 | Registered combined pending interrupt |
| recheck | output | 1 | One-cycle strobe after a mask write that exposes a request |

## Verification
Status and mask change at the clock edge that samples the request. `cpu_irq` and `recheck` follow one edge later, and read data with `bus_rvalid` appears at the edge after the read is sampled. The bench drives inputs on the falling edge. A behavioural model then predicts, for the coming rising edge, the values each output must carry, using the register contents that model held before that edge. Every output is compared at the following falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;
  localparam int IRQ_W   = 16;
  localparam int ADDR_W  = 12;
  localparam int DATA_W  = 32;
  localparam int DMA_BIT = 3;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 12'h070;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 12'h074;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_MASK   = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_mask_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int IW = IRQ_W,
  parameter logic [AW-1:0] STAT_OFS = OFS_STATUS,
  parameter logic [AW-1:0] MASK_OFS = OFS_MASK
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [IW-1:0] cur_status,
  input  logic [IW-1:0] cur_mask,
  output logic          ack_wr,
  output logic          mask_wr,
  output logic [IW-1:0] wr_word,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  localparam int PAD_W = DW - IW;

  reg_sel_e sel;
  logic     rd_req;

  always_comb begin
    if (req_addr == STAT_OFS)      sel = SEL_STATUS;
    else if (req_addr == MASK_OFS) sel = SEL_MASK;
    else                           sel = SEL_NONE;
  end

  assign rd_req  = req_valid && !req_write;
  assign ack_wr  = req_valid && req_write && (sel == SEL_STATUS);
  assign mask_wr = req_valid && req_write && (sel == SEL_MASK);
  assign wr_word = req_wdata[IW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) begin
        case (sel)
          SEL_STATUS: rd_data <= {{PAD_W{1'b0}}, cur_status};
          SEL_MASK:   rd_data <= {{PAD_W{1'b0}}, cur_mask};
          default:    rd_data <= '0;
        endcase
      end else begin
        rd_data <= '0;
      end
    end
  end
endmodule

// File: rtl/irq_status_bits.sv
module irq_status_bits #(
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] set_vec,
  input  logic          ack_wr,
  input  logic [IW-1:0] ack_word,
  output logic [IW-1:0] status
);
  for (genvar b = 0; b < IW; b++) begin : g_bit
    logic keep;
    assign keep = !ack_wr || ack_word[b];
    always_ff @(posedge clk) begin
      if (rst) status[b] <= 1'b0;
      else     status[b] <= set_vec[b] | (status[b] & keep);
    end
  end
endmodule

// File: rtl/irq_pend_eval.sv
module irq_pend_eval #(
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mask_wr,
  input  logic [IW-1:0] mask_word,
  input  logic [IW-1:0] status,
  output logic [IW-1:0] mask,
  output logic          pend,
  output logic          strobe
);
  logic mask_wr_q;
  logic hit;

  assign hit = |(status & mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask      <= '0;
      mask_wr_q <= 1'b0;
      pend      <= 1'b0;
      strobe    <= 1'b0;
    end else begin
      if (mask_wr) mask <= mask_word;
      mask_wr_q <= mask_wr;
      pend      <= hit;
      strobe    <= mask_wr_q && hit;
    end
  end
endmodule

// File: rtl/irq_mask_ctl.sv
module irq_mask_ctl
  import irq_mask_pkg::*;
#(
  parameter int IW = IRQ_W,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int DMA_IDX = DMA_BIT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_rvalid,
  input  logic [IW-1:0] irq_set,
  input  logic          dma_irq,
  output logic          cpu_irq,
  output logic          recheck
);
  logic [IW-1:0] status_q;
  logic [IW-1:0] mask_q;
  logic [IW-1:0] set_all;
  logic [IW-1:0] wr_word;
  logic          ack_wr;
  logic          mask_wr;

  assign set_all = irq_set | (IW'(dma_irq) << DMA_IDX);

  irq_bus_decode #(.AW(AW), .DW(DW), .IW(IW)) u_dec (
    .clk(clk), .rst(rst),
    .req_valid(bus_valid), .req_write(bus_write),
    .req_addr(bus_addr), .req_wdata(bus_wdata),
    .cur_status(status_q), .cur_mask(mask_q),
    .ack_wr(ack_wr), .mask_wr(mask_wr), .wr_word(wr_word),
    .rd_data(bus_rdata), .rd_valid(bus_rvalid)
  );

  irq_status_bits #(.IW(IW)) u_stat (
    .clk(clk), .rst(rst), .set_vec(set_all),
    .ack_wr(ack_wr), .ack_word(wr_word), .status(status_q)
  );

  irq_pend_eval #(.IW(IW)) u_pend (
    .clk(clk), .rst(rst), .mask_wr(mask_wr), .mask_word(wr_word),
    .status(status_q), .mask(mask_q), .pend(cpu_irq), .strobe(recheck)
  );
endmodule

// File: rtl/irq_mask_ctl_chk.sv
module irq_mask_ctl_chk #(
  parameter int IW = 16,
  parameter int AW = 12,
  parameter int DMA_IDX = 3,
  parameter logic [AW-1:0] MASK_OFS = 12'h074
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_valid,
  input logic          bus_write,
  input logic [AW-1:0] bus_addr,
  input logic [IW-1:0] irq_set,
  input logic          dma_irq,
  input logic [IW-1:0] status_q,
  input logic [IW-1:0] mask_q,
  input logic          cpu_irq,
  input logic          recheck,
  input logic          bus_rvalid
);
  logic mask_req;
  assign mask_req = bus_valid && bus_write && (bus_addr == MASK_OFS);

  // R1: reset empties both registers
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (status_q == '0 && mask_q == '0 && !cpu_irq && !recheck));

  // R2: a requested bit is present after the edge
  a_r2_set_sticky: assert property (@(posedge clk) disable iff (rst)
    |irq_set |=> ((status_q & $past(irq_set)) == $past(irq_set)));

  // R9: DMA request lands on its reserved bit
  a_r9_dma_bit: assert property (@(posedge clk) disable iff (rst)
    dma_irq |=> status_q[DMA_IDX]);

  // R6: pending line follows registers with one cycle of delay
  a_r6_pend_delay: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (cpu_irq == $past(|(status_q & mask_q))));

  // R7: strobe only with pending and only after a mask write
  a_r7_strobe_with_pend: assert property (@(posedge clk) disable iff (rst)
    recheck |-> cpu_irq);
  a_r7_strobe_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(recheck) |-> $past(mask_req, 2));

  // R8: read data valid one cycle after each read
  a_r8_rvalid_timing: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (bus_rvalid == $past(bus_valid && !bus_write)));
endmodule

bind irq_mask_ctl irq_mask_ctl_chk #(.IW(IW), .AW(AW), .DMA_IDX(DMA_IDX)) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .irq_set(irq_set), .dma_irq(dma_irq),
  .status_q(status_q), .mask_q(mask_q), .cpu_irq(cpu_irq),
  .recheck(recheck), .bus_rvalid(bus_rvalid)
);

// File: tb/irq_mask_ctl_tb.sv
`timescale 1ns/1ps
module irq_mask_ctl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [15:0] irq_set = '0;
  logic        dma_irq = 1'b0;
  logic        cpu_irq;
  logic        recheck;

  always #5 clk = ~clk;

  irq_mask_ctl u_dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq_set(irq_set), .dma_irq(dma_irq),
    .cpu_irq(cpu_irq), .recheck(recheck)
  );

  int n_cmp = 0;
  int n_bad = 0;
  string tag = "R1";
  bit done = 0;

  // model state
  logic [15:0] ms = '0, mm = '0;
  logic        mwr = 1'b0;
  logic        e_pend = 0, e_rchk = 0, e_rv = 0;
  logic [31:0] e_rd = '0;

  task automatic check(input string t, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", t, what, got, exp);
    end
  endtask

  task automatic cycle(input logic v, input logic w, input logic [11:0] a,
                       input logic [31:0] d, input logic [15:0] s, input logic dm);
    logic [15:0] ns;
    bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d;
    irq_set = s; dma_irq = dm;
    if (rst) begin
      e_pend = 0; e_rchk = 0; e_rv = 0; e_rd = '0; ms = '0; mm = '0; mwr = 0;
    end else begin
      e_pend = |(ms & mm);
      e_rchk = mwr && |(ms & mm);
      e_rv   = v && !w;
      e_rd   = '0;
      if (v && !w && a == 12'h070) e_rd = {16'h0, ms};
      if (v && !w && a == 12'h074) e_rd = {16'h0, mm};
      ns = ms;
      if (v && w && a == 12'h070) ns = ms & d[15:0];
      ns = ns | s;
      if (dm) ns[3] = 1'b1;
      mwr = v && w && a == 12'h074;
      if (mwr) mm = d[15:0];
      ms = ns;
    end
    @(posedge clk);
    @(negedge clk);
    check("R6", "cpu_irq", {31'b0, cpu_irq}, {31'b0, e_pend});
    check("R7", "recheck", {31'b0, recheck}, {31'b0, e_rchk});
    check(tag, "rvalid", {31'b0, bus_rvalid}, {31'b0, e_rv});
    check(tag, "rdata", bus_rdata, e_rd);
  endtask

  task automatic idle();        cycle(0, 0, 12'h0, 32'h0, 16'h0, 0); endtask
  task automatic rd(input logic [11:0] a); cycle(1, 0, a, 32'h0, 16'h0, 0); endtask
  task automatic wr(input logic [11:0] a, input logic [31:0] d); cycle(1, 1, a, d, 16'h0, 0); endtask

  initial begin
    #200000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset state, including a set pulse applied during reset
    cycle(1, 1, 12'h074, 32'hFFFF, 16'hFFFF, 1);
    idle();
    rst = 1'b0;
    tag = "R1"; rd(12'h070); rd(12'h074); idle();
    // R2: peripheral pulses stick
    tag = "R2"; cycle(0, 0, 12'h0, 32'h0, 16'h0005, 0); idle(); rd(12'h070);
    // R9: DMA request sets bit 3
    tag = "R9"; cycle(0, 0, 12'h0, 32'h0, 16'h0, 1); rd(12'h070);
    // R3: acknowledge by AND clears only zero bits
    tag = "R3"; wr(12'h070, 32'h0000_FFF7); rd(12'h070);
    wr(12'h070, 32'hFFFF_FFFE); rd(12'h070);
    // R4: set wins over same-cycle clear
    tag = "R4"; cycle(1, 1, 12'h070, 32'h0, 16'h0104, 0); rd(12'h070);
    // R5: mask write uses low half only
    tag = "R5"; wr(12'h074, 32'hABCD_00F0); rd(12'h074); idle();
    // R7: mask uncovering pending bit 8 gives strobe, pend rises
    tag = "R7"; wr(12'h074, 32'h0000_0100); idle(); idle(); idle();
    wr(12'h074, 32'h0000_0100); idle(); idle();
    wr(12'h074, 32'h0); idle(); idle();
    // R6: pend follows a set with the mask open, and an ack
    tag = "R6"; wr(12'h074, 32'h0000_0010); idle();
    cycle(0, 0, 12'h0, 32'h0, 16'h0010, 0); idle(); idle();
    wr(12'h070, 32'h0000_FFEF); idle(); idle();
    // R8: unmapped read is zero, unmapped write touches nothing
    tag = "R8"; rd(12'h100); wr(12'h078, 32'h0); wr(12'h000, 32'h0);
    rd(12'h070); rd(12'h074); idle();
    // mixed traffic
    tag = "R6";
    for (int i = 0; i < 3000; i++) begin
      logic [11:0] a;
      int k;
      k = $urandom_range(0, 3);
      a = (k == 0) ? 12'h070 : (k == 1) ? 12'h074 : (k == 2) ? 12'h070 : 12'h07C;
      cycle($urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1, a,
            $urandom, ($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'h0,
            $urandom_range(0, 7) == 0);
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule